// File: doc/BRIEF.md
# Configurable-Edge Serial Frame Sampler

This block receives a serial system-side bit stream, a companion signaling stream and a frame-sync pulse. All three are timed by an external serial clock. The block runs on its own fast clock. It brings the serial clock and the three serial inputs through a shared synchronizer, so all four keep their timing relative to each other. It then finds the serial clock edges inside its own clock domain.

Static configuration inputs set the behaviour:
- One bit picks the serial clock edge, rising or falling, on which the frame pulse is taken. A second bit picks the edge on which data and signaling are taken.
- A rate bit lets the serial clock run at twice the bit rate. In that case a further bit chooses which of the two data-type edges in each bit does the sampling.
- A polarity bit makes the frame pulse active-low.
- A length bit sets the frame to 256 or 193 bits.

For each bit the block gives out one strobe, together with the sampled data bit, the sampled signaling bit and the bit's position in the frame. The position counts from the last accepted frame pulse.

Top module: `serial_frame_sampler`

## Requirements
- R1: While reset is asserted and after its release, `bit_stb`, `bit_dat`, `bit_sig`, `bit_cnt` and `aligned` are all 0, until the first accepted frame pulse.
- R2: No strobe is issued before the first accepted frame pulse. `aligned` goes to 1 when that pulse is accepted and stays at 1 until reset.
- R3: `cfg_fs_fall` selects the frame-pulse edge and `cfg_dat_fall` selects the data edge (0 means rising, 1 means falling). When the two selects are equal, the pulse is sampled on the first data edge of bit 0. When they differ, the pulse is sampled on the opposite edge half a serial clock period earlier, and the next data edge belongs to bit 0.
- R4: With `cfg_fs_low`=0 the frame pulse is active when `fsync` is high. With `cfg_fs_low`=1 it is active when `fsync` is low.
- R5: The strobe for the first bit after an accepted pulse carries `bit_cnt`=0. Each later bit carries the previous value plus one.
- R6: With `cfg_t1`=0, `bit_cnt` wraps from 255 to 0. With `cfg_t1`=1, it wraps from 192 to 0.
- R7: With `cfg_dbl`=1, each bit spans two serial clock periods and still gives exactly one strobe. `cfg_late`=0 samples on the first data-type edge of the bit and `cfg_late`=1 on the second.
- R8: With `cfg_dbl`=1, after alignment, a frame pulse seen on the second frame-type edge of a bit is ignored, and the count continues unchanged.
- R9: `bit_sig` is captured on the same edge as `bit_dat` and is reported with the same strobe.
- R10: A later accepted frame pulse restarts the count, so the next bit is reported with `bit_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fs_fall | input | 1 | Frame-pulse sampling edge, 1 = falling |
| cfg_dat_fall | input | 1 | Data and signaling sampling edge, 1 = falling |
| cfg_dbl | input | 1 | Serial clock at twice the bit rate |
| cfg_late | input | 1 | In double-rate mode, sample on the second data edge of the bit |
| cfg_fs_low | input | 1 | Frame pulse active-low |
| cfg_t1 | input | 1 | 193-bit frame (0 selects 256-bit) |
| sck | input | 1 | External serial clock |
| fsync | input | 1 | Frame-sync pulse |
| sdat | input | 1 | Serial data |
| ssig | input | 1 | Serial signaling |
| bit_stb | output | 1 | One-cycle strobe per received bit |
| bit_dat | output | 1 | Sampled data bit |
| bit_sig | output | 1 | Sampled signaling bit |
| bit_cnt | output | CW | Bit position in the frame |
| aligned | output | 1 | A frame pulse has been accepted |

## Verification
The bench builds the block with its default parameters: a 256-bit long frame, a 193-bit short frame and a two-stage synchronizer. These defaults make both wrap points reachable in a few hundred bits, so every bit index can be checked against a computed stream.

In double-rate runs, the bench drives a different data value on each half of every bit. This makes a strobe taken on the wrong one of the two edges show up as a data mismatch. Misplaced pulses and mid-frame realignment are placed at chosen bits, so the expected count sequence is known exactly.

// File: rtl/serial_frame_sampler.sv
module serial_frame_sampler #(
  parameter int LONG_BITS  = 256,
  parameter int SHORT_BITS = 193,
  parameter int SYNC       = 2,
  localparam int CW        = $clog2(LONG_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fs_fall,
  input  logic          cfg_dat_fall,
  input  logic          cfg_dbl,
  input  logic          cfg_late,
  input  logic          cfg_fs_low,
  input  logic          cfg_t1,
  input  logic          sck,
  input  logic          fsync,
  input  logic          sdat,
  input  logic          ssig,
  output logic          bit_stb,
  output logic          bit_dat,
  output logic          bit_sig,
  output logic [CW-1:0] bit_cnt,
  output logic          aligned
);

  logic [SYNC-1:0] sck_q, fs_q, sd_q, sg_q;
  logic            sck_d;
  logic            pend, ph;
  logic [CW-1:0]   nbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= '0;
      fs_q  <= '0;
      sd_q  <= '0;
      sg_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[SYNC-2:0], sck};
      fs_q  <= {fs_q[SYNC-2:0], fsync};
      sd_q  <= {sd_q[SYNC-2:0], sdat};
      sg_q  <= {sg_q[SYNC-2:0], ssig};
      sck_d <= sck_q[SYNC-1];
    end
  end

  wire rise   = sck_q[SYNC-1] & ~sck_d;
  wire fall   = ~sck_q[SYNC-1] & sck_d;
  wire fs_ev  = cfg_fs_fall ? fall : rise;
  wire d_ev   = cfg_dat_fall ? fall : rise;
  wire fs_act = fs_q[SYNC-1] ^ cfg_fs_low;

  wire [CW-1:0] last = cfg_t1 ? CW'(SHORT_BITS - 1) : CW'(LONG_BITS - 1);

  wire fs_ok = fs_ev & fs_act & (~cfg_dbl | ~aligned | ~ph);
  wire start = d_ev & (pend | fs_ok);

  wire [CW-1:0] cur_bit = start ? '0 : nbit;
  wire          cur_ph  = start ? 1'b0 : ph;
  wire          sel_ph  = cfg_dbl & cfg_late;
  wire          take    = (aligned | start) & (cur_ph == sel_ph);
  wire          end_bit = ~cfg_dbl | cur_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      ph      <= 1'b0;
      nbit    <= '0;
      aligned <= 1'b0;
      bit_stb <= 1'b0;
      bit_dat <= 1'b0;
      bit_sig <= 1'b0;
      bit_cnt <= '0;
    end else begin
      bit_stb <= d_ev & take;
      if (fs_ok) aligned <= 1'b1;
      if (d_ev) begin
        pend <= 1'b0;
        ph   <= cfg_dbl & ~cur_ph;
        if (end_bit) nbit <= (cur_bit == last) ? '0 : cur_bit + 1'b1;
        else         nbit <= cur_bit;
        if (take) begin
          bit_dat <= sd_q[SYNC-1];
          bit_sig <= sg_q[SYNC-1];
          bit_cnt <= cur_bit;
        end
      end else if (fs_ok) begin
        pend <= 1'b1;
      end
    end
  end

  logic          seen;
  logic [CW-1:0] prev_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      prev_cnt <= '0;
    end else if (bit_stb) begin
      seen     <= 1'b1;
      prev_cnt <= bit_cnt;
    end
  end

  p_aligned_before_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> aligned);

  p_cnt_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (bit_cnt <= last));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && seen) |-> (bit_cnt == '0 || bit_cnt == CW'(prev_cnt + 1'b1)));

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

endmodule

// File: tb/serial_frame_sampler_test.sv
module serial_frame_sampler_test;
  localparam int CW = 8;
  localparam int NR = 8;
  localparam int MAXR = 300;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_fs_fall = 0, cfg_dat_fall = 0, cfg_dbl = 0, cfg_late = 0, cfg_fs_low = 0, cfg_t1 = 0;
  logic sck = 0, fsync = 0, sdat = 0, ssig = 0;
  logic bit_stb, bit_dat, bit_sig, aligned;
  logic [CW-1:0] bit_cnt;

  serial_frame_sampler uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_fs_fall(cfg_fs_fall), .cfg_dat_fall(cfg_dat_fall), .cfg_dbl(cfg_dbl),
    .cfg_late(cfg_late), .cfg_fs_low(cfg_fs_low), .cfg_t1(cfg_t1),
    .sck(sck), .fsync(fsync), .sdat(sdat), .ssig(ssig),
    .bit_stb(bit_stb), .bit_dat(bit_dat), .bit_sig(bit_sig),
    .bit_cnt(bit_cnt), .aligned(aligned)
  );

  // fs_fall, dat_fall, dbl, late, fs_low, t1, bits, realign bit, misplaced bit, seed
  localparam int T [NR][10] = '{
    '{0, 0, 0, 0, 0, 0, 259,  0,  0, 1},
    '{1, 0, 0, 0, 0, 1, 196,  0,  0, 2},
    '{0, 1, 0, 0, 1, 0,  40, 20,  0, 3},
    '{1, 1, 0, 0, 1, 1,  30,  0,  0, 4},
    '{0, 0, 1, 0, 0, 1, 196,  0, 10, 5},
    '{0, 0, 1, 1, 0, 0,  40,  0, 12, 6},
    '{1, 0, 1, 1, 1, 0,  40, 25,  8, 7},
    '{0, 1, 1, 0, 0, 1,  30, 15,  5, 0}
  };

  int checks = 0, fails = 0;
  logic clr = 1'b1;
  int rec_n;
  int rc [MAXR];
  logic rd [MAXR];
  logic rs [MAXR];

  always @(negedge clk) begin
    if (clr) rec_n <= 0;
    else if (bit_stb && rec_n < MAXR) begin
      rc[rec_n] <= int'(bit_cnt);
      rd[rec_n] <= bit_dat;
      rs[rec_n] <= bit_sig;
      rec_n <= rec_n + 1;
    end
  end

  function automatic logic dpat(int k, int seed);
    return logic'((((k * 7 + seed) >> 1) ^ k ^ (k >> 3)) & 1);
  endfunction

  function automatic logic spat(int k, int seed);
    return logic'((((k * 3 + seed) >> 2) ^ (k >> 1)) & 1);
  endfunction

  task automatic check(bit ok, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic do_reset(int r);
    clr = 1'b1;
    rst_n = 1'b0;
    cfg_fs_fall = T[r][0][0]; cfg_dat_fall = T[r][1][0]; cfg_dbl = T[r][2][0];
    cfg_late = T[r][3][0]; cfg_fs_low = T[r][4][0]; cfg_t1 = T[r][5][0];
    sck = 1'b0; fsync = cfg_fs_low; sdat = 1'b0; ssig = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic edge_out(logic f, logic d, logic s);
    fsync = f; sdat = d; ssig = s;
    repeat (2) @(negedge clk);
    sck = ~sck;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_row(int r);
    int diff, dr, e0, nb, rb, bb, seed, len, n;
    do_reset(r);
    diff = (T[r][0] != T[r][1]) ? 1 : 0;
    dr   = T[r][2] ? 4 : 2;
    e0   = 8 + T[r][1];
    nb   = T[r][6]; rb = T[r][7]; bb = T[r][8]; seed = T[r][9];
    len  = T[r][5] ? 193 : 256;
    for (int e = 0; e < e0 + dr * nb; e++) begin
      logic d, s, fa;
      if (e >= e0 - 1) begin
        int rel, k, half;
        rel = e - e0 + 1;
        k = rel / dr;
        half = T[r][2] ? (rel % dr) / 2 : 0;
        d = dpat(k, seed); s = spat(k, seed);
        if (T[r][2] != 0 && half != T[r][3]) begin d = ~d; s = ~s; end
      end else begin
        d = logic'(e & 1); s = logic'((e >> 1) & 1);
      end
      fa = (e == e0 - diff) || (rb > 0 && e == e0 + dr * rb - diff) ||
           (bb > 0 && e == e0 + dr * bb - diff + 2);
      edge_out(fa ^ cfg_fs_low, d, s);
    end
    repeat (8) @(negedge clk);
    check(rec_n == nb, $sformatf("R7 strobe count row %0d", r), rec_n, nb);
    check(aligned == 1'b1, $sformatf("R2 aligned row %0d", r), int'(aligned), 1);
    n = (rec_n < nb) ? rec_n : nb;
    for (int j = 0; j < n; j++) begin
      int ec;
      ec = ((rb > 0 && j >= rb) ? j - rb : j) % len;
      check(rc[j] == ec,
        $sformatf("R3 R4 R5 R6 R8 R10 count row %0d bit %0d", r, j), rc[j], ec);
      check(rd[j] == dpat(j, seed) && rs[j] == spat(j, seed),
        $sformatf("R7 R9 data/sig row %0d bit %0d", r, j),
        int'({rd[j], rs[j]}), int'({dpat(j, seed), spat(j, seed)}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    do_reset(0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(bit_stb == 0 && bit_cnt == 0 && aligned == 0 && bit_dat == 0 && bit_sig == 0,
      "R1 reset state", int'({bit_stb, bit_dat, bit_sig, aligned}) + int'(bit_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(aligned == 0 && bit_cnt == 0, "R1 after release", int'(aligned) + int'(bit_cnt), 0);

    for (int e = 0; e < 40; e++) edge_out(cfg_fs_low, logic'(e & 1), logic'((e >> 1) & 1));
    repeat (8) @(negedge clk);
    check(rec_n == 0, "R2 no strobe before frame pulse", rec_n, 0);
    check(aligned == 0, "R2 aligned stays low", int'(aligned), 0);

    for (int r = 0; r < NR; r++) run_row(r);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule